// File: doc/BRIEF.md
# Ring Command Port for a Shared Accelerator

This block sits between one ring network port and an accelerator that has a streaming data port and a register-style configuration port. The same ring link carries both stream samples and the words used to save and reload the accelerator's internal state. Bit 15 of each word's transfer address tells the block whether the word is data or a command. Command words carry an accelerator ID, a mode, a burst count and a start address. A command aimed at another accelerator is passed down the chain unchanged. A command aimed at this one switches the block's mode.

The block has four modes. In normal mode, stream data flows through the accelerator. In write mode, arriving words are stored into consecutive configuration registers. In read mode, consecutive configuration registers are fetched and sent onto the ring. In bypass mode, data skips the accelerator entirely. A counted read or write burst drops back to normal mode on its own when it finishes. Everything that leaves toward the next ring stage goes to a single fixed forward address.

Top module: `ring_rwi`

## Requirements
- R1: Reset is synchronous and active low. After reset the block is in bypass mode, `out_valid`, `acc_in_valid`, `cfg_we` and `cfg_re` are low, and `acc_out_ready` is low.
- R2: A valid incoming word with `in_addr[15]` = 1 is treated as a command. With `in_addr[15]` = 0 it is treated as data. No other address bit affects behaviour.
- R3: A command whose ID field `in_data[31:20]` differs from parameter `MY_ID` appears one cycle later on the ring output. It keeps the same data, and its address is `FWD_ADDR` with bit 15 forced to 1. This holds in every mode.
- R4: A command whose ID equals `MY_ID` is not forwarded. It sets the mode from `in_data[19:18]`: 00 normal, 10 read, 01 write, 11 bypass. For read and write it also loads the burst count from `in_data[17:12]` and the start address from `in_data[11:0]`. A matching command overrides any burst in progress.
- R5: In normal mode, a data word appears on `acc_in_valid`/`acc_in_data` one cycle later. An accelerator result accepted with `acc_out_valid && acc_out_ready` appears one cycle later on the ring output, at address `FWD_ADDR` with bit 15 = 0.
- R6: In write mode, each data word drives `cfg_we` in the same cycle, with `cfg_wdata` equal to the word. `cfg_addr` starts at the commanded address and rises by one per word. The word does not reach the accelerator.
- R7: In read mode, on each cycle with no matching command and no incoming word that needs the ring output, the block raises `cfg_re` at the current address. `cfg_rdata` in that cycle is sent one cycle later to `FWD_ADDR` with bit 15 = 0. The address then rises by one.
- R8: When a read or write burst's count reaches zero, the mode returns to normal. A read or write command with count 0 enters normal mode directly.
- R9: In bypass mode, each data word is sent one cycle later to `FWD_ADDR` with bit 15 = 0, and `acc_in_valid` stays low.
- R10: The ring output serves one source per cycle, in this priority order: an incoming word to forward, then a configuration read, then an accelerator result. When an incoming word is being forwarded, `acc_out_ready` is low and any read is postponed.
- R11: In read mode, an incoming data word is forwarded like in bypass mode. `acc_out_ready` is high only in normal mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming ring word valid |
| in_addr | input | 16 | Incoming transfer address; bit 15 marks a command |
| in_data | input | 32 | Incoming ring word |
| out_valid | output | 1 | Outgoing ring word valid |
| out_addr | output | 16 | Outgoing transfer address |
| out_data | output | 32 | Outgoing ring word |
| acc_in_valid | output | 1 | Stream word to accelerator valid |
| acc_in_data | output | 32 | Stream word to accelerator |
| acc_out_valid | input | 1 | Accelerator result valid |
| acc_out_data | input | 32 | Accelerator result |
| acc_out_ready | output | 1 | Block accepts the accelerator result this cycle |
| cfg_we | output | 1 | Configuration write strobe |
| cfg_re | output | 1 | Configuration read strobe |
| cfg_addr | output | 12 | Configuration register address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rdata | input | 32 | Configuration read data, valid in the cycle of `cfg_re` |

## Verification
Two functions compete for the single ring output in the same cycle. The first case is an incoming word that must be forwarded while a read burst is waiting to send, which is provoked by a foreign command and by a stray data word arriving mid-burst. The second case is a foreign command arriving while the accelerator is presenting a result. In both cases the bench expects the forwarded word to appear on the next cycle and the pending source to be held. It judges this by `cfg_re` or `acc_out_ready` staying low in the clash cycle, and by the held word appearing unchanged, at its unchanged address, on the cycle after.

// File: rtl/ring_rwi_pkg.sv
// Shared widths, mode encoding and command word layout for the ring
// command port. The layout is fixed because upstream gateways build it.
package ring_rwi_pkg;

    localparam int DATA_W = 32;
    localparam int RADDR_W = 16;
    localparam int ID_W = 12;
    localparam int CNT_W = 6;
    localparam int CA_W = 12;
    localparam int CMD_FLAG = 15;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_WRITE  = 2'b01,
        MODE_READ   = 2'b10,
        MODE_BYPASS = 2'b11
    } mode_e;

    typedef struct packed {
        logic [ID_W-1:0]  id;
        mode_e            mode;
        logic [CNT_W-1:0] cnt;
        logic [CA_W-1:0]  addr;
    } cmd_t;

endpackage

// File: rtl/ring_rwi_decode.sv
// Classifies one incoming ring word as data, a command for this
// accelerator, or a command for another one.
// Assumes at most one ring word per cycle.
module ring_rwi_decode
    import ring_rwi_pkg::*;
#(
    parameter logic [ID_W-1:0] MY_ID = 12'h05A
) (
    input  logic              in_valid,
    input  logic              cmd_flag,
    input  logic [DATA_W-1:0] in_data,
    output logic              data_word,
    output logic              own_cmd,
    output logic              foreign_cmd,
    output cmd_t              cmd
);

    // Split the word into command fields and classify it.
    always_comb begin
        cmd         = cmd_t'(in_data);
        data_word   = in_valid && !cmd_flag;
        own_cmd     = in_valid && cmd_flag && (cmd.id == MY_ID);
        foreign_cmd = in_valid && cmd_flag && (cmd.id != MY_ID);
    end

endmodule

// File: rtl/ring_rwi_mode_ctl.sv
// Holds the operating mode, the configuration pointer and the burst
// count. Produces the configuration strobes.
// Assumes the configuration port accepts a write and returns read data
// in the same cycle as the strobe.
module ring_rwi_mode_ctl
    import ring_rwi_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            own_cmd,
    input  mode_e           cmd_mode,
    input  logic [CNT_W-1:0] cmd_cnt,
    input  logic [CA_W-1:0] cmd_addr,
    input  logic            data_word,
    input  logic            ring_busy,
    output mode_e           mode,
    output logic [CA_W-1:0] ptr,
    output logic            wr_fire,
    output logic            rd_fire
);

    logic [CNT_W-1:0] cnt_q;
    logic             burst_mode;

    // Decide whether a configuration access happens this cycle.
    always_comb begin
        wr_fire    = (mode == MODE_WRITE) && data_word && (cnt_q != '0);
        rd_fire    = (mode == MODE_READ) && (cnt_q != '0) && !ring_busy && !own_cmd;
        burst_mode = (cmd_mode == MODE_READ) || (cmd_mode == MODE_WRITE);
    end

    // Update the mode, pointer and count on commands and burst steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= MODE_BYPASS;
            ptr   <= '0;
            cnt_q <= '0;
        end else if (own_cmd) begin
            mode  <= (burst_mode && cmd_cnt == '0) ? MODE_NORMAL : cmd_mode;
            ptr   <= cmd_addr;
            cnt_q <= cmd_cnt;
        end else if (wr_fire || rd_fire) begin
            ptr   <= ptr + 1'b1;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                mode <= MODE_NORMAL;
            end
        end
    end

endmodule

// File: rtl/ring_rwi_egress.sv
// Registered ring output stage. It picks one source per cycle, in
// priority order: a forwarded incoming word, then configuration read
// data, then an accelerator result.
// Assumes the downstream link never back-pressures.
module ring_rwi_egress
    import ring_rwi_pkg::*;
#(
    parameter logic [RADDR_W-1:0] FWD_ADDR = 16'h0040
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pass_en,
    input  logic               pass_is_cmd,
    input  logic [DATA_W-1:0]  pass_data,
    input  logic               rd_en,
    input  logic [DATA_W-1:0]  rd_data,
    input  logic               acc_en,
    input  logic [DATA_W-1:0]  acc_data,
    output logic               out_valid,
    output logic [RADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0]  out_data
);

    localparam logic [RADDR_W-2:0] FWD_LOW = FWD_ADDR[RADDR_W-2:0];

    // Register the chosen word together with its command marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_data  <= '0;
        end else if (pass_en) begin
            out_valid <= 1'b1;
            out_addr  <= {pass_is_cmd, FWD_LOW};
            out_data  <= pass_data;
        end else if (rd_en) begin
            out_valid <= 1'b1;
            out_addr  <= {1'b0, FWD_LOW};
            out_data  <= rd_data;
        end else if (acc_en) begin
            out_valid <= 1'b1;
            out_addr  <= {1'b0, FWD_LOW};
            out_data  <= acc_data;
        end else begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/ring_rwi.sv
// Ring command port for one shared accelerator. It steers ring words to
// the accelerator, to its configuration registers, or onward, based on
// the command marker and the current mode.
// Assumes one ring word per cycle and an accelerator that always accepts input.
module ring_rwi
    import ring_rwi_pkg::*;
#(
    parameter logic [11:0] MY_ID    = 12'h05A,
    parameter logic [15:0] FWD_ADDR = 16'h0040
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [15:0] in_addr,
    input  logic [31:0] in_data,
    output logic        out_valid,
    output logic [15:0] out_addr,
    output logic [31:0] out_data,
    output logic        acc_in_valid,
    output logic [31:0] acc_in_data,
    input  logic        acc_out_valid,
    input  logic [31:0] acc_out_data,
    output logic        acc_out_ready,
    output logic        cfg_we,
    output logic        cfg_re,
    output logic [11:0] cfg_addr,
    output logic [31:0] cfg_wdata,
    input  logic [31:0] cfg_rdata
);

    logic            data_word, own_cmd, foreign_cmd;
    cmd_t            cmd;
    mode_e           mode_q;
    logic [CA_W-1:0] ptr;
    logic            wr_fire, rd_fire;
    logic            pass_data, ring_busy, acc_fire;
    logic            unused_addr_bits;

    assign unused_addr_bits = ^in_addr[CMD_FLAG-1:0];

    ring_rwi_decode #(.MY_ID(MY_ID)) u_decode (
        .in_valid    (in_valid),
        .cmd_flag    (in_addr[CMD_FLAG]),
        .in_data     (in_data),
        .data_word   (data_word),
        .own_cmd     (own_cmd),
        .foreign_cmd (foreign_cmd),
        .cmd         (cmd)
    );

    // Work out who needs the ring output and whether the accelerator may send.
    always_comb begin
        pass_data     = data_word && (mode_q == MODE_BYPASS || mode_q == MODE_READ);
        ring_busy     = foreign_cmd || pass_data;
        acc_out_ready = (mode_q == MODE_NORMAL) && !ring_busy;
        acc_fire      = acc_out_valid && acc_out_ready;
    end

    ring_rwi_mode_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_cmd   (own_cmd),
        .cmd_mode  (cmd.mode),
        .cmd_cnt   (cmd.cnt),
        .cmd_addr  (cmd.addr),
        .data_word (data_word),
        .ring_busy (ring_busy),
        .mode      (mode_q),
        .ptr       (ptr),
        .wr_fire   (wr_fire),
        .rd_fire   (rd_fire)
    );

    assign cfg_we    = wr_fire;
    assign cfg_re    = rd_fire;
    assign cfg_addr  = ptr;
    assign cfg_wdata = in_data;

    ring_rwi_egress #(.FWD_ADDR(FWD_ADDR)) u_egress (
        .clk         (clk),
        .rst_n       (rst_n),
        .pass_en     (ring_busy),
        .pass_is_cmd (foreign_cmd),
        .pass_data   (in_data),
        .rd_en       (rd_fire),
        .rd_data     (cfg_rdata),
        .acc_en      (acc_fire),
        .acc_data    (acc_out_data),
        .out_valid   (out_valid),
        .out_addr    (out_addr),
        .out_data    (out_data)
    );

    // Present normal-mode stream words to the accelerator one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_in_valid <= 1'b0;
            acc_in_data  <= '0;
        end else begin
            acc_in_valid <= data_word && (mode_q == MODE_NORMAL);
            if (data_word) begin
                acc_in_data <= in_data;
            end
        end
    end

endmodule

// File: rtl/ring_rwi_checker.sv
// Temporal properties of the ring command port, bound to every instance.
module ring_rwi_checker
    import ring_rwi_pkg::*;
#(
    parameter logic [11:0] MY_ID    = 12'h05A,
    parameter logic [15:0] FWD_ADDR = 16'h0040
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [15:0] in_addr,
    input logic [31:0] in_data,
    input logic        out_valid,
    input logic [15:0] out_addr,
    input logic [31:0] out_data,
    input logic        acc_in_valid,
    input logic [31:0] acc_in_data,
    input logic        acc_out_valid,
    input logic [31:0] acc_out_data,
    input logic        acc_out_ready,
    input logic        cfg_we,
    input logic        cfg_re,
    input logic [11:0] cfg_addr,
    input logic [31:0] cfg_rdata,
    input logic [1:0]  mode
);

    assert_reset_bypass_R1: assert property (@(posedge clk)
        !rst_n |=> (mode == MODE_BYPASS) && !out_valid && !acc_in_valid);

    assert_foreign_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr[15] && in_data[31:20] != MY_ID)
        |=> out_valid && out_addr == {1'b1, FWD_ADDR[14:0]} && out_data == $past(in_data));

    assert_normal_feed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_addr[15] && mode == MODE_NORMAL)
        |=> acc_in_valid && acc_in_data == $past(in_data));

    assert_result_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_out_valid && acc_out_ready)
        |=> out_valid && !out_addr[15] && out_data == $past(acc_out_data));

    assert_write_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_addr == $past(cfg_addr) + 12'd1);

    assert_read_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_re |=> out_valid && !out_addr[15] && out_data == $past(cfg_rdata));

    assert_bypass_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_addr[15] && mode == MODE_BYPASS)
        |=> out_valid && !acc_in_valid && out_data == $past(in_data));

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr[15] && in_data[31:20] != MY_ID) |-> !cfg_re && !acc_out_ready);

    assert_ready_normal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_NORMAL) |-> !acc_out_ready);

endmodule

bind ring_rwi ring_rwi_checker #(.MY_ID(MY_ID), .FWD_ADDR(FWD_ADDR)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_addr       (in_addr),
    .in_data       (in_data),
    .out_valid     (out_valid),
    .out_addr      (out_addr),
    .out_data      (out_data),
    .acc_in_valid  (acc_in_valid),
    .acc_in_data   (acc_in_data),
    .acc_out_valid (acc_out_valid),
    .acc_out_data  (acc_out_data),
    .acc_out_ready (acc_out_ready),
    .cfg_we        (cfg_we),
    .cfg_re        (cfg_re),
    .cfg_addr      (cfg_addr),
    .cfg_rdata     (cfg_rdata),
    .mode          (mode_q)
);

// File: tb/ring_rwi_bench.sv
// Vector table walk followed by directed reset and corner-case tests.
module ring_rwi_bench;

    localparam int PERIOD = 10;
    localparam logic [11:0] ID = 12'h05A;
    localparam logic [15:0] FWD = 16'h0040;
    localparam int NV = 19;

    typedef struct packed {
        logic        iv;
        logic [15:0] ia;
        logic [31:0] id;
        logic        eov;
        logic [15:0] eoa;
        logic [31:0] eod;
        logic        eav;
        logic [31:0] ead;
        logic        ewe;
        logic        ere;
        logic [11:0] eca;
    } vec_t;

    // Command words: {id[31:20], mode[19:18], count[17:12], addr[11:0]}.
    localparam vec_t TBL [NV] = '{
        {1'b1,16'h0002,32'h11111111, 1'b1,16'h0040,32'h11111111, 1'b0,32'h0, 1'b0,1'b0,12'h000}, // R9 bypass
        {1'b1,16'h8000,32'h12300000, 1'b1,16'h8040,32'h12300000, 1'b0,32'h0, 1'b0,1'b0,12'h000}, // R3 foreign
        {1'b1,16'h8000,32'h05A00000, 1'b0,16'h0,32'h0, 1'b0,32'h0, 1'b0,1'b0,12'h000},            // R4 normal
        {1'b1,16'h0002,32'h22222222, 1'b0,16'h0,32'h0, 1'b1,32'h22222222, 1'b0,1'b0,12'h000},     // R5
        {1'b1,16'h8000,32'h05A42010, 1'b0,16'h0,32'h0, 1'b0,32'h0, 1'b0,1'b0,12'h000},            // R4 write
        {1'b1,16'h0002,32'hAAAA0001, 1'b0,16'h0,32'h0, 1'b0,32'h0, 1'b1,1'b0,12'h010},            // R6
        {1'b1,16'h0002,32'hAAAA0002, 1'b0,16'h0,32'h0, 1'b0,32'h0, 1'b1,1'b0,12'h011},            // R6
        {1'b1,16'h0002,32'h33333333, 1'b0,16'h0,32'h0, 1'b1,32'h33333333, 1'b0,1'b0,12'h000},     // R8
        {1'b1,16'h8000,32'h05A82010, 1'b0,16'h0,32'h0, 1'b0,32'h0, 1'b0,1'b0,12'h000},            // R4 read
        {1'b0,16'h0000,32'h00000000, 1'b1,16'h0040,32'hAAAA0001, 1'b0,32'h0, 1'b0,1'b1,12'h010},  // R7
        {1'b1,16'h8000,32'h7FF40000, 1'b1,16'h8040,32'h7FF40000, 1'b0,32'h0, 1'b0,1'b0,12'h000},  // R10
        {1'b0,16'h0000,32'h00000000, 1'b1,16'h0040,32'hAAAA0002, 1'b0,32'h0, 1'b0,1'b1,12'h011},  // R7
        {1'b1,16'h0002,32'h44444444, 1'b0,16'h0,32'h0, 1'b1,32'h44444444, 1'b0,1'b0,12'h000},     // R8
        {1'b1,16'h8000,32'h05A82030, 1'b0,16'h0,32'h0, 1'b0,32'h0, 1'b0,1'b0,12'h000},            // R4 read
        {1'b1,16'h0002,32'h66666666, 1'b1,16'h0040,32'h66666666, 1'b0,32'h0, 1'b0,1'b0,12'h000},  // R11
        {1'b0,16'h0000,32'h00000000, 1'b1,16'h0040,32'hC0000030, 1'b0,32'h0, 1'b0,1'b1,12'h030},  // R7
        {1'b1,16'h8000,32'h05AC0000, 1'b0,16'h0,32'h0, 1'b0,32'h0, 1'b0,1'b0,12'h000},            // R4 abort
        {1'b1,16'h0002,32'h77777777, 1'b1,16'h0040,32'h77777777, 1'b0,32'h0, 1'b0,1'b0,12'h000},  // R9
        {1'b0,16'h0000,32'h00000000, 1'b0,16'h0,32'h0, 1'b0,32'h0, 1'b0,1'b0,12'h000}             // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic        acc_out_valid = 1'b0;
    logic [31:0] acc_out_data = '0;
    logic        out_valid, acc_in_valid, acc_out_ready, cfg_we, cfg_re;
    logic [15:0] out_addr;
    logic [31:0] out_data, acc_in_data, cfg_wdata, cfg_rdata;
    logic [11:0] cfg_addr;
    logic [31:0] cfg_mem [64];

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    ring_rwi #(.MY_ID(ID), .FWD_ADDR(FWD)) u_ring_rwi (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr), .in_data(in_data),
        .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data),
        .acc_in_valid(acc_in_valid), .acc_in_data(acc_in_data),
        .acc_out_valid(acc_out_valid), .acc_out_data(acc_out_data), .acc_out_ready(acc_out_ready),
        .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata)
    );

    // Configuration register model: same-cycle read, written at the edge.
    initial for (int i = 0; i < 64; i++) cfg_mem[i] = 32'hC0000000 | i;
    always @(posedge clk) if (cfg_we) cfg_mem[cfg_addr[5:0]] <= cfg_wdata;
    assign cfg_rdata = cfg_mem[cfg_addr[5:0]];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic iv, input logic [15:0] ia, input logic [31:0] id);
        @(negedge clk);
        in_valid = iv;
        in_addr  = ia;
        in_data  = id;
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state before release.
        chk(!out_valid, "R1 out_valid", {31'b0, out_valid}, 32'h0);
        chk(!acc_in_valid, "R1 acc_in_valid", {31'b0, acc_in_valid}, 32'h0);
        chk(!acc_out_ready && !cfg_we && !cfg_re, "R1 ready/strobes",
            {29'b0, acc_out_ready, cfg_we, cfg_re}, 32'h0);
        rst_n = 1'b1;

        // Table walk: inputs at negedge, strobes mid-low phase, registered outputs after edge.
        for (int v = 0; v < NV; v++) begin
            drive(TBL[v].iv, TBL[v].ia, TBL[v].id);
            #(PERIOD/4);
            chk(cfg_we == TBL[v].ewe, "R6 cfg_we", {31'b0, cfg_we}, {31'b0, TBL[v].ewe});
            chk(cfg_re == TBL[v].ere, "R7/R10 cfg_re", {31'b0, cfg_re}, {31'b0, TBL[v].ere});
            if (TBL[v].ewe || TBL[v].ere)
                chk(cfg_addr == TBL[v].eca, "R6/R7 cfg_addr", {20'b0, cfg_addr}, {20'b0, TBL[v].eca});
            @(posedge clk);
            #1;
            chk(out_valid == TBL[v].eov, "R3/R9 out_valid", {31'b0, out_valid}, {31'b0, TBL[v].eov});
            if (TBL[v].eov) begin
                chk(out_addr == TBL[v].eoa, "R3 out_addr", {16'b0, out_addr}, {16'b0, TBL[v].eoa});
                chk(out_data == TBL[v].eod, "R7 out_data", out_data, TBL[v].eod);
            end
            chk(acc_in_valid == TBL[v].eav, "R5 acc_in_valid", {31'b0, acc_in_valid}, {31'b0, TBL[v].eav});
            if (TBL[v].eav)
                chk(acc_in_data == TBL[v].ead, "R5 acc_in_data", acc_in_data, TBL[v].ead);
        end

        // R5: accelerator result leaves on the ring in normal mode.
        drive(1'b1, 16'h8000, 32'h05A00000);
        drive(1'b0, 16'h0, 32'h0);
        acc_out_valid = 1'b1;
        acc_out_data  = 32'hBEEF0001;
        #(PERIOD/4);
        chk(acc_out_ready, "R5 ready in normal", {31'b0, acc_out_ready}, 32'h1);
        @(posedge clk); #1;
        chk(out_valid && out_addr == 16'h0040 && out_data == 32'hBEEF0001, "R5 result out",
            out_data, 32'hBEEF0001);

        // R10: foreign command and accelerator result in the same cycle.
        drive(1'b1, 16'h8000, 32'h3C100000);
        acc_out_data = 32'hBEEF0002;
        #(PERIOD/4);
        chk(!acc_out_ready, "R10 ready held low", {31'b0, acc_out_ready}, 32'h0);
        @(posedge clk); #1;
        chk(out_valid && out_addr == 16'h8040 && out_data == 32'h3C100000, "R10 command wins",
            out_data, 32'h3C100000);
        drive(1'b0, 16'h0, 32'h0);
        #(PERIOD/4);
        chk(acc_out_ready, "R10 ready returns", {31'b0, acc_out_ready}, 32'h1);
        @(posedge clk); #1;
        chk(out_valid && out_addr == 16'h0040 && out_data == 32'hBEEF0002, "R10 held result",
            out_data, 32'hBEEF0002);
        acc_out_valid = 1'b0;

        // R8: write command with count zero lands in normal mode.
        drive(1'b1, 16'h8000, 32'h05A40000);
        drive(1'b1, 16'h0002, 32'h12345678);
        #(PERIOD/4);
        chk(!cfg_we, "R8 no write at count 0", {31'b0, cfg_we}, 32'h0);
        @(posedge clk); #1;
        chk(acc_in_valid && acc_in_data == 32'h12345678, "R8 data to acc", acc_in_data, 32'h12345678);

        // R4: matching command aborts a write burst; R2 ignores low address bits.
        drive(1'b1, 16'h8000, 32'h05A45020);
        drive(1'b1, 16'h7FFF, 32'h0000ABCD);
        #(PERIOD/4);
        chk(cfg_we && cfg_addr == 12'h020, "R6 burst first write", {20'b0, cfg_addr}, 32'h020);
        drive(1'b1, 16'hFFFF, 32'h05A00000);
        drive(1'b1, 16'h0002, 32'h0000BEAD);
        #(PERIOD/4);
        chk(!cfg_we, "R4 burst aborted", {31'b0, cfg_we}, 32'h0);
        @(posedge clk); #1;
        chk(acc_in_valid && acc_in_data == 32'h0000BEAD, "R4 normal after abort", acc_in_data, 32'h0000BEAD);
        chk(cfg_mem[32] == 32'h0000ABCD, "R6 stored word", cfg_mem[32], 32'h0000ABCD);
        drive(1'b0, 16'h0, 32'h0);

        // R1: reset mid-run returns to bypass.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 16'h0002, 32'h5A5A5A5A);
        @(posedge clk); #1;
        chk(out_valid && !acc_in_valid && out_data == 32'h5A5A5A5A, "R1 bypass after reset",
            out_data, 32'h5A5A5A5A);
        drive(1'b0, 16'h0, 32'h0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule